// File: doc/BRIEF.md
# Serial Link Transmitter with Coarse Word Delay

The block turns one parallel word per slow-clock period into a serial bit stream. It runs on the fast bit clock only. A load strobe, high for one fast cycle in every eight, tells the block when to capture the next word. The word is shifted out most significant bit first, one bit per fast clock. In the same cycle that the first bit of each word leaves the block, a marker output goes high.

The receiver captures whole words against its own slow clock. That capture edge sits at an unknown bit offset from the transmitter's word edge. To line the two up, a three-bit setting adds 0 to 7 bit periods of delay to the whole stream. An operator can also replace the live word with a fixed alignment pattern. The default pattern is seven ones and one zero, so it always has transitions and the position of the single zero shows directly where the word edge lies.

Inside the block, a loader state machine captures and shifts each word. It has two states. ST_IDLE means nothing is being sent. ST_SEND means a word is being shifted out. The transitions are:
- ST_IDLE to ST_SEND when the strobe is high.
- ST_SEND to ST_SEND when the strobe is high, which reloads the next word.
- ST_SEND to ST_IDLE when the last bit has been shifted and no strobe is present.

A tapped delay line then applies the delay setting. That setting is captured at the same moment as the word.

Top module: `ser_link_tx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, ser_out and word_mark are 0.
- R2: A word is captured on a clock edge where ld_stb is high. Its 8 bits then appear on ser_out one per clock, bit 7 first and bit 0 last.
- R3: If use_pat is high at the load edge, that word is replaced by the test pattern 8'hFE. The choice is made separately for each load.
- R4: With delay setting D (0 to 7) held steady, bit 7 of a word loaded at edge E appears on ser_out after edge E+1+D.
- R5: word_mark is high in exactly those cycles in which ser_out carries bit 7 of a word.
- R6: dly_sel is sampled only at load edges. A change between loads leaves the output timing unchanged until the next load edge, and the new delay applies from the following edge onward.
- R7: ser_out and word_mark are 0 before the first load after reset. They are also 0 once the last bit of the final word has left, when no further load follows.
- R8: Each emitted pattern word contains both bit values. Its only 0 is the last bit, seven cycles after the marker.
- R9: While in ST_SEND, ld_stb may only be high on the eighth cycle after the previous load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_stb | input | 1 | One-cycle word load strobe, once per eight clocks |
| use_pat | input | 1 | High selects the test pattern at this load |
| word_in | input | 8 | Live parallel word |
| dly_sel | input | 3 | Coarse delay in bit periods |
| ser_out | output | 1 | Serial bit stream |
| word_mark | output | 1 | High while ser_out carries a word's first bit |

## Verification
The bench sweeps every delay setting from 0 to 7 under three source patterns: all live words, all pattern words, and live and pattern words alternating. Live words are chosen so that each delay and each word position gives a different bit sequence. A wrong latency, a reversed bit order or a stuck select therefore shows up as a mismatch at a known bit position. Further runs change the delay in the middle of a word, both upward and downward. These tell a delay that is sampled at the load edge apart from one that is sampled at any time. The tail of every run checks that the line drains to zero.

// File: rtl/ser_link_pkg.sv
package ser_link_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic dat;
        logic mark;
    } tx_bit_t;

endpackage

// File: rtl/ser_word_loader.sv
module ser_word_loader
    import ser_link_pkg::*;
#(
    parameter int unsigned          WORD_W   = 8,
    parameter logic [WORD_W-1:0]    TEST_PAT = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_stb,
    input  logic              use_pat,
    input  logic [WORD_W-1:0] word_in,
    output tx_bit_t           raw_o,
    output tx_state_e         state_o
);

    localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    tx_state_e          state_q, state_d;
    logic [WORD_W-1:0]  shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               first_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ld_stb) state_d = ST_SEND;
            ST_SEND: begin
                if (ld_stb)             state_d = ST_SEND;
                else if (cnt_q == LAST) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // word capture and shifting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else if (ld_stb) begin
            shreg_q <= use_pat ? TEST_PAT : word_in;
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else begin
            first_q <= 1'b0;
            if (state_q == ST_SEND) begin
                shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        raw_o.dat  = shreg_q[WORD_W-1];
        raw_o.mark = first_q;
        state_o    = state_q;
    end

    assert_load_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && state_q == ST_SEND) |-> (cnt_q == LAST));

    assert_mark_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> $past(ld_stb));

    assert_pattern_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_stb && use_pat)) |-> (shreg_q == TEST_PAT));

endmodule

// File: rtl/ser_coarse_delay.sv
module ser_coarse_delay
    import ser_link_pkg::*;
#(
    parameter int unsigned DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_stb,
    input  logic [DLY_W-1:0] dly_sel,
    input  tx_bit_t          raw_i,
    output logic             ser_o,
    output logic             mark_o
);

    localparam int unsigned MAX_DLY = (1 << DLY_W) - 1;

    tx_bit_t            line_q [MAX_DLY];
    logic [DLY_W-1:0]   dly_act_q;
    tx_bit_t            tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dly_act_q <= '0;
        else if (ld_stb) dly_act_q <= dly_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q[0] <= '0;
        else        line_q[0] <= raw_i;
    end

    for (genvar g = 1; g < MAX_DLY; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q[g] <= '0;
            else        line_q[g] <= line_q[g-1];
        end
    end

    always_comb begin
        tap = raw_i;
        for (int i = 0; i < MAX_DLY; i++) begin
            if (dly_act_q == DLY_W'(i + 1)) tap = line_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_o  <= 1'b0;
            mark_o <= 1'b0;
        end else begin
            ser_o  <= tap.dat;
            mark_o <= tap.mark;
        end
    end

    assert_delay_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld_stb)) |-> $stable(dly_act_q));

endmodule

// File: rtl/ser_link_tx.sv
module ser_link_tx
    import ser_link_pkg::*;
#(
    parameter int unsigned          WORD_W   = 8,
    parameter int unsigned          DLY_W    = 3,
    parameter logic [WORD_W-1:0]    TEST_PAT = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_stb,
    input  logic              use_pat,
    input  logic [WORD_W-1:0] word_in,
    input  logic [DLY_W-1:0]  dly_sel,
    output logic              ser_out,
    output logic              word_mark
);

    tx_bit_t   raw;
    tx_state_e st;

    ser_word_loader #(.WORD_W(WORD_W), .TEST_PAT(TEST_PAT)) u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_stb  (ld_stb),
        .use_pat (use_pat),
        .word_in (word_in),
        .raw_o   (raw),
        .state_o (st)
    );

    ser_coarse_delay #(.DLY_W(DLY_W)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_stb  (ld_stb),
        .dly_sel (dly_sel),
        .raw_i   (raw),
        .ser_o   (ser_out),
        .mark_o  (word_mark)
    );

    // tracks whether any load has happened since reset, for the check below
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_q | ld_stb;
    end

    assert_quiet_before_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && st == ST_IDLE) |-> (!ser_out && !word_mark));

endmodule

// File: tb/tb_ser_link_tx.sv
module tb_ser_link_tx;

    localparam int CLK_P = 10;
    localparam int NW    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_stb = 1'b0;
    logic       use_pat = 1'b0;
    logic [7:0] word_in = '0;
    logic [2:0] dly_sel = '0;
    logic       ser_out, word_mark;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] wq [NW];

    always #(CLK_P/2) clk = ~clk;

    ser_link_tx dut (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .use_pat(use_pat),
        .word_in(word_in), .dly_sel(dly_sel),
        .ser_out(ser_out), .word_mark(word_mark)
    );

    task automatic check(input logic act, input logic exp, input string tag, input int ctx);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s ctx=%0d actual=%b expected=%b", tag, ctx, act, exp);
        end
    endtask

    // d0: delay at first load, d1: delay applied mid-word, active from edge 8
    task automatic run_case(input int d0, input int d1, input int pmode);
        bit pk [NW];
        int total;
        total = 8*NW + 2 + ((d0 > d1) ? d0 : d1) + 4;
        rst_n = 1'b0; ld_stb = 1'b0; use_pat = 1'b0; dly_sel = 3'(d0);
        for (int k = 0; k < NW; k++) begin
            pk[k] = (pmode == 1) || (pmode == 2 && k[0]);
            wq[k] = pk[k] ? 8'hFE : (8'hA5 ^ 8'(d0 * 8'h11) ^ 8'(k * 8'h37) ^ 8'(pmode << 6));
        end
        repeat (2) @(negedge clk);
        check(ser_out, 1'b0, "R1 reset ser_out", d0);
        check(word_mark, 1'b0, "R1 reset mark", d0);
        rst_n = 1'b1;
        for (int m = 0; m <= total; m++) begin
            @(negedge clk);
            if (m >= 1) begin
                int c, d, n, k, j;
                logic eb, em;
                string tag;
                c = m - 1;
                d = (c <= 8) ? d0 : d1;
                n = c - 1 - d;
                eb = 1'b0; em = 1'b0;
                tag = (d0 != d1) ? "R6 R4" : "R4 R2";
                if (n < 0 || n >= 8*NW) begin
                    tag = (c == 0) ? "R1 R7" : "R7";
                end else begin
                    k = n / 8; j = n % 8;
                    eb = wq[k][7-j];
                    em = (j == 0);
                    if (pk[k]) tag = (j == 7) ? "R8 R3" : "R3";
                end
                check(ser_out, eb, tag, m);
                check(word_mark, em, "R5 mark", m);
            end
            ld_stb  = (m % 8 == 0) && (m / 8 < NW);
            use_pat = ld_stb ? pk[(m/8) % NW] : 1'b0;
            word_in = ld_stb ? (pk[(m/8) % NW] ? 8'h5A : wq[(m/8) % NW]) : 8'h00;
            if (m == 3) dly_sel = 3'(d1);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int d = 0; d < 8; d++)
            for (int p = 0; p < 3; p++)
                run_case(d, d, p);
        run_case(2, 6, 0);
        run_case(7, 0, 0);
        run_case(0, 7, 2);
        run_case(5, 1, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule